// File: doc/BRIEF.md
# Indirect Control Port for a Block-Cipher Engine with Saved Chaining Values

This block is the host side of a block-cipher engine. The host reaches everything through one byte-wide data port plus a selector. The selector names what the data port touches:

- Selector 0x03: a data write loads the register index, and a data read returns engine status.
- Selector 0x04: data accesses go to the indirect register named by the index.
- Selector 0x08: data accesses move cipher bytes in and out.

The indirect registers hold the following:

- the port configuration;
- a transfer (DMA) mode byte;
- one key-slot pointer per cipher stage;
- the cipher mode;
- a processed-block counter;
- a byte-serial load path for the running chaining value (IV);
- a command register.

The command register starts and stops the engine. It can also park the running chaining value in one of two save slots when the engine stops. It can bring a slot back and restart in a single command, so a long message can be split into chunks without reloading the IV.

The cipher itself is replaced by a stub. Once eight input bytes are buffered and the engine runs, the stub emits the input block XOR the running IV. It then increments the IV and counts the block.

Top module: `cipher_ctrl_port`

## Requirements
- R1: After synchronous reset, every indirect register, both save slots and the running IV are zero. The engine is idle and both byte buffers are empty, so a status read returns 0x04.
- R2: A data write while the selector is 0x03 loads the index. Status reads at selector 0x03 leave the index unchanged. The index persists across selector changes, so later accesses at selector 0x04 still reach the same register.
- R3: Repeated data writes at selector 0x04 all target the current index. At index 0x03 each write shifts one byte into the running IV from the low end, so after eight writes the first byte is the most significant.
- R4: Indices 0x10, 0x11 and 0x12 hold the key pointers of stages 0, 1 and 2 (low 4 bits kept). Writes to 0x11 and 0x12 are ignored while mode bit 1 (triple cipher) is clear.
- R5: Index 0x00 (configuration; bit 0 read enable, bit 1 write enable of the external data port), index 0x02 (transfer mode) and index 0x13 (mode: bit 0 decrypt, bit 1 triple, bit 2 extended key, bits 7:4 chaining 0 ECB, 1 CBC, 2 OFB, 3 CFB, 4 key stream, 5 MAC) read back what was written. Unlisted indices read 0.
- R6: Command 0x01 at index 0x14 starts the engine. Any start command (0x01, 0x05, 0x07) while the engine runs has no effect, and the IV is not restored.
- R7: Commands 0x04 and 0x06 stop the engine and copy the running IV into slot 1 or slot 2. They do this even when the engine is already idle.
- R8: Commands 0x05 and 0x07 from idle copy slot 1 or slot 2 into the running IV and start the engine.
- R9: Command 0x00 stops the engine and discards any buffered input and output bytes.
- R10: Command 0x08 zeroes configuration, transfer mode, mode, key pointers and block counter. It also stops the engine and empties the buffers, but keeps both slots and the running IV.
- R11: The status byte has bit 0 = running, bit 1 = eight input bytes buffered, bit 2 = output buffer empty. Input bytes are written at selector 0x08, and writes beyond eight are dropped. When the engine runs with a full input and an empty output, the block is processed at the first clock edge with no indirect-register write. Processing produces eight output bytes (input XOR IV, read most significant first at selector 0x08), increments the IV and the counter, and empties the input. A read with no output bytes returns 0.
- R12: Index 0x0B reads and writes the block counter, which wraps from 0xFF to 0x00 on a processed block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Load the selector with sel_val |
| sel_val | input | 8 | New selector value |
| dat_we | input | 1 | Data write at the current selector |
| dat_re | input | 1 | Data read at the current selector (pops an output byte at 0x08) |
| dat_wdata | input | 8 | Write data |
| dat_rdata | output | 8 | Read data for the current selector, combinational |
| cipher_active | output | 1 | Engine running flag |

## Verification
The bench builds the block at its defaults: 8-byte blocks, three cipher stages, 4-bit key pointers and an 8-bit block counter. The small counter puts the 0xFF to 0x00 wrap one block away. Three stages make the triple-cipher gating of the second and third pointers observable. Eight-byte buffers let each full/empty transition and the drop of extra input bytes show up in a handful of cycles. With a 64-bit IV, save, restore and increment show up directly in the stub output when zero input is fed.

// File: rtl/civ_pkg.sv
package civ_pkg;

    // selector values of the host data port
    localparam logic [7:0] SEL_INDEX = 8'h03;
    localparam logic [7:0] SEL_IDATA = 8'h04;
    localparam logic [7:0] SEL_XDATA = 8'h08;

    // indirect register indices
    localparam logic [7:0] IX_CFG    = 8'h00;
    localparam logic [7:0] IX_DMA    = 8'h02;
    localparam logic [7:0] IX_IVLD   = 8'h03;
    localparam logic [7:0] IX_BLKCNT = 8'h0B;
    localparam logic [7:0] IX_KPTR0  = 8'h10;
    localparam logic [7:0] IX_MODE   = 8'h13;
    localparam logic [7:0] IX_CMD    = 8'h14;

    typedef enum logic [7:0] {
        CMD_HALT  = 8'h00,
        CMD_RUN   = 8'h01,
        CMD_SAVE1 = 8'h04,
        CMD_LOAD1 = 8'h05,
        CMD_SAVE2 = 8'h06,
        CMD_LOAD2 = 8'h07,
        CMD_CLEAR = 8'h08
    } cmd_e;

    typedef struct packed {
        logic [3:0] chain;
        logic       spare;
        logic       ext_key;
        logic       triple;
        logic       decrypt;
    } mode_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } iwr_t;

    function automatic logic [7:0] status_byte(logic act, logic full, logic empty);
        return {5'b0, empty, full, act};
    endfunction

    function automatic logic is_start(logic [7:0] c);
        return (c == CMD_RUN) || (c == CMD_LOAD1) || (c == CMD_LOAD2);
    endfunction

    function automatic logic is_stop(logic [7:0] c);
        return (c == CMD_HALT) || (c == CMD_SAVE1) || (c == CMD_SAVE2) || (c == CMD_CLEAR);
    endfunction

endpackage

// File: rtl/civ_host_decode.sv
module civ_host_decode
    import civ_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_we,
    input  logic [7:0] sel_val,
    input  logic       dat_we,
    input  logic       dat_re,
    input  logic [7:0] dat_wdata,
    output logic [7:0] sel_q,
    output logic [7:0] idx_q,
    output iwr_t       iwr,
    output logic       x_wr,
    output logic       x_rd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            idx_q <= '0;
        end else begin
            if (sel_we)
                sel_q <= sel_val;
            if (dat_we && sel_q == SEL_INDEX)
                idx_q <= dat_wdata;
        end
    end

    always_comb begin
        iwr.en   = dat_we && (sel_q == SEL_IDATA);
        iwr.idx  = idx_q;
        iwr.data = dat_wdata;
        x_wr     = dat_we && (sel_q == SEL_XDATA);
        x_rd     = dat_re && !dat_we && (sel_q == SEL_XDATA);
    end

endmodule

// File: rtl/civ_regfile.sv
module civ_regfile
    import civ_pkg::*;
#(
    parameter int STAGES = 3,
    parameter int KEY_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  iwr_t                          iwr,
    output logic [7:0]                    cfg_q,
    output logic [7:0]                    dma_q,
    output mode_t                         mode_q,
    output logic [STAGES-1:0][KEY_W-1:0]  kptr_q
);

    logic wipe;
    assign wipe = iwr.en && (iwr.idx == IX_CMD) && (iwr.data == CMD_CLEAR);

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            cfg_q  <= '0;
            dma_q  <= '0;
            mode_q <= '0;
        end else if (iwr.en) begin
            if (iwr.idx == IX_CFG)  cfg_q  <= iwr.data;
            if (iwr.idx == IX_DMA)  dma_q  <= iwr.data;
            if (iwr.idx == IX_MODE) mode_q <= mode_t'(iwr.data);
        end
    end

    // one pointer per stage; stages past the first only exist in triple mode
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam logic [7:0] KIX = IX_KPTR0 + 8'(s);
        logic [KEY_W-1:0] kp;
        logic             usable;
        assign usable = (s == 0) ? 1'b1 : mode_q.triple;

        always_ff @(posedge clk) begin
            if (rst || wipe)
                kp <= '0;
            else if (iwr.en && iwr.idx == KIX && usable)
                kp <= iwr.data[KEY_W-1:0];
        end
        assign kptr_q[s] = kp;
    end

endmodule

// File: rtl/civ_engine_stub.sv
module civ_engine_stub
    import civ_pkg::*;
#(
    parameter int BLK_BYTES = 8,
    parameter int DBC_W     = 8,
    localparam int IV_W     = 8 * BLK_BYTES,
    localparam int CNT_W    = $clog2(BLK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  iwr_t             iwr,
    input  logic             x_wr,
    input  logic             x_rd,
    output logic             active_q,
    output logic             in_full,
    output logic             out_empty,
    output logic [7:0]       out_byte,
    output logic [DBC_W-1:0] dbc_q,
    output logic [IV_W-1:0]  run_iv_q,
    output logic [IV_W-1:0]  slot1_q,
    output logic [IV_W-1:0]  slot2_q,
    output logic [CNT_W-1:0] in_cnt_q,
    output logic [CNT_W-1:0] out_cnt_q
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLK_BYTES);

    logic [IV_W-1:0] in_blk_q;
    logic [IV_W-1:0] out_blk_q;
    logic            cmd_we;
    logic            blk_go;

    assign cmd_we    = iwr.en && (iwr.idx == IX_CMD);
    assign in_full   = (in_cnt_q == FULL_CNT);
    assign out_empty = (out_cnt_q == '0);
    assign blk_go    = active_q && in_full && out_empty && !iwr.en;
    assign out_byte  = out_empty ? 8'h00 : out_blk_q[IV_W-1 -: 8];

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            dbc_q     <= '0;
            run_iv_q  <= '0;
            slot1_q   <= '0;
            slot2_q   <= '0;
            in_cnt_q  <= '0;
            out_cnt_q <= '0;
            in_blk_q  <= '0;
            out_blk_q <= '0;
        end else begin
            if (cmd_we) begin
                case (iwr.data)
                    CMD_HALT: begin
                        active_q  <= 1'b0;
                        in_cnt_q  <= '0;
                        out_cnt_q <= '0;
                    end
                    CMD_RUN: active_q <= 1'b1;
                    CMD_SAVE1: begin
                        active_q <= 1'b0;
                        slot1_q  <= run_iv_q;
                    end
                    CMD_SAVE2: begin
                        active_q <= 1'b0;
                        slot2_q  <= run_iv_q;
                    end
                    CMD_LOAD1: if (!active_q) begin
                        run_iv_q <= slot1_q;
                        active_q <= 1'b1;
                    end
                    CMD_LOAD2: if (!active_q) begin
                        run_iv_q <= slot2_q;
                        active_q <= 1'b1;
                    end
                    CMD_CLEAR: begin
                        active_q  <= 1'b0;
                        in_cnt_q  <= '0;
                        out_cnt_q <= '0;
                        dbc_q     <= '0;
                    end
                    default: ;
                endcase
            end else if (iwr.en && iwr.idx == IX_IVLD) begin
                run_iv_q <= {run_iv_q[IV_W-9:0], iwr.data};
            end else if (iwr.en && iwr.idx == IX_BLKCNT) begin
                dbc_q <= DBC_W'(iwr.data);
            end

            if (x_wr && !in_full) begin
                in_blk_q <= {in_blk_q[IV_W-9:0], iwr.data};
                in_cnt_q <= in_cnt_q + CNT_W'(1);
            end

            if (x_rd && !out_empty) begin
                out_blk_q <= out_blk_q << 8;
                out_cnt_q <= out_cnt_q - CNT_W'(1);
            end

            if (blk_go) begin
                out_blk_q <= in_blk_q ^ run_iv_q;
                out_cnt_q <= FULL_CNT;
                in_cnt_q  <= '0;
                run_iv_q  <= run_iv_q + IV_W'(1);
                dbc_q     <= dbc_q + DBC_W'(1);
            end
        end
    end

endmodule

// File: rtl/cipher_ctrl_port.sv
module cipher_ctrl_port
    import civ_pkg::*;
#(
    parameter int BLK_BYTES = 8,
    parameter int STAGES    = 3,
    parameter int KEY_W     = 4,
    parameter int DBC_W     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_we,
    input  logic [7:0] sel_val,
    input  logic       dat_we,
    input  logic       dat_re,
    input  logic [7:0] dat_wdata,
    output logic [7:0] dat_rdata,
    output logic       cipher_active
);

    localparam int IV_W  = 8 * BLK_BYTES;
    localparam int CNT_W = $clog2(BLK_BYTES + 1);

    logic [7:0]                   sel_q;
    logic [7:0]                   idx_q;
    iwr_t                         iwr;
    logic                         x_wr;
    logic                         x_rd;
    logic [7:0]                   cfg_q;
    logic [7:0]                   dma_q;
    mode_t                        mode_q;
    logic [STAGES-1:0][KEY_W-1:0] kptr_q;
    logic                         in_full;
    logic                         out_empty;
    logic [7:0]                   out_byte;
    logic [DBC_W-1:0]             dbc_q;
    logic [IV_W-1:0]              run_iv;
    logic [IV_W-1:0]              iv_slot1;
    logic [IV_W-1:0]              iv_slot2;
    logic [CNT_W-1:0]             in_cnt;
    logic [CNT_W-1:0]             out_cnt;

    civ_host_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (sel_we),
        .sel_val   (sel_val),
        .dat_we    (dat_we),
        .dat_re    (dat_re),
        .dat_wdata (dat_wdata),
        .sel_q     (sel_q),
        .idx_q     (idx_q),
        .iwr       (iwr),
        .x_wr      (x_wr),
        .x_rd      (x_rd)
    );

    civ_regfile #(.STAGES(STAGES), .KEY_W(KEY_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .iwr    (iwr),
        .cfg_q  (cfg_q),
        .dma_q  (dma_q),
        .mode_q (mode_q),
        .kptr_q (kptr_q)
    );

    civ_engine_stub #(.BLK_BYTES(BLK_BYTES), .DBC_W(DBC_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .iwr       (iwr),
        .x_wr      (x_wr),
        .x_rd      (x_rd),
        .active_q  (cipher_active),
        .in_full   (in_full),
        .out_empty (out_empty),
        .out_byte  (out_byte),
        .dbc_q     (dbc_q),
        .run_iv_q  (run_iv),
        .slot1_q   (iv_slot1),
        .slot2_q   (iv_slot2),
        .in_cnt_q  (in_cnt),
        .out_cnt_q (out_cnt)
    );

    logic [7:0] ireg_rd;

    always_comb begin
        ireg_rd = 8'h00;
        case (idx_q)
            IX_CFG:    ireg_rd = cfg_q;
            IX_DMA:    ireg_rd = dma_q;
            IX_BLKCNT: ireg_rd = 8'(dbc_q);
            IX_MODE:   ireg_rd = mode_q;
            default: begin
                for (int s = 0; s < STAGES; s++)
                    if (idx_q == IX_KPTR0 + 8'(s))
                        ireg_rd = 8'(kptr_q[s]);
            end
        endcase
    end

    always_comb begin
        case (sel_q)
            SEL_INDEX: dat_rdata = status_byte(cipher_active, in_full, out_empty);
            SEL_IDATA: dat_rdata = ireg_rd;
            SEL_XDATA: dat_rdata = out_byte;
            default:   dat_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/cipher_ctrl_port_chk.sv
module cipher_ctrl_port_chk
    import civ_pkg::*;
#(
    parameter int BLK_BYTES = 8,
    parameter int STAGES    = 3,
    parameter int KEY_W     = 4,
    localparam int IV_W     = 8 * BLK_BYTES,
    localparam int CNT_W    = $clog2(BLK_BYTES + 1)
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         dat_we,
    input logic [7:0]                   dat_wdata,
    input logic [7:0]                   sel_q,
    input logic [7:0]                   idx_q,
    input logic                         cipher_active,
    input logic [CNT_W-1:0]             in_cnt,
    input logic [CNT_W-1:0]             out_cnt,
    input logic [IV_W-1:0]              run_iv,
    input logic [IV_W-1:0]              iv_slot1,
    input logic [IV_W-1:0]              iv_slot2,
    input mode_t                        mode_q,
    input logic [STAGES-1:0][KEY_W-1:0] kptr_q
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BLK_BYTES);

    logic iw, cmdw;
    assign iw   = dat_we && (sel_q == SEL_IDATA);
    assign cmdw = iw && (idx_q == IX_CMD);

    assert_idx_kept_R2: assert property (@(posedge clk) disable iff (rst)
        !dat_we |=> $stable(idx_q));

    assert_kptr_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.triple && !(cmdw && dat_wdata == CMD_CLEAR)) |=> $stable(kptr_q[STAGES-1]));

    assert_restart_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (cipher_active && cmdw && is_start(dat_wdata)) |=> (cipher_active && $stable(run_iv)));

    assert_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (cmdw && is_stop(dat_wdata)) |=> !cipher_active);

    assert_save_slot1_R7: assert property (@(posedge clk) disable iff (rst)
        (cmdw && dat_wdata == CMD_SAVE1) |=> (iv_slot1 == $past(run_iv)));

    assert_clear_keeps_iv_R10: assert property (@(posedge clk) disable iff (rst)
        (cmdw && dat_wdata == CMD_CLEAR) |=> ($stable(iv_slot1) && $stable(iv_slot2) && $stable(run_iv)));

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (rst)
        (in_cnt <= FULL_CNT) && (out_cnt <= FULL_CNT));

    assert_block_step_R11: assert property (@(posedge clk) disable iff (rst)
        (cipher_active && in_cnt == FULL_CNT && out_cnt == '0 && !iw)
            |=> (run_iv == $past(run_iv) + IV_W'(1) && out_cnt == FULL_CNT && in_cnt == '0));

endmodule

bind cipher_ctrl_port cipher_ctrl_port_chk #(
    .BLK_BYTES (BLK_BYTES),
    .STAGES    (STAGES),
    .KEY_W     (KEY_W)
) u_chk (.*);

// File: tb/cipher_ctrl_port_tb.sv
module cipher_ctrl_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_we = 1'b0;
    logic [7:0] sel_val = '0;
    logic       dat_we = 1'b0;
    logic       dat_re = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       cipher_active;

    always #4 clk = ~clk;

    cipher_ctrl_port u_dut (
        .clk           (clk),
        .rst           (rst),
        .sel_we        (sel_we),
        .sel_val       (sel_val),
        .dat_we        (dat_we),
        .dat_re        (dat_re),
        .dat_wdata     (dat_wdata),
        .dat_rdata     (dat_rdata),
        .cipher_active (cipher_active)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    mon_on = 1'b0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    byte unsigned m_in[$];
    byte unsigned m_out[$];
    logic [7:0]   m_sel, m_idx, m_cfg, m_dma, m_mode, m_dbc;
    logic [3:0]   m_kp[3];
    logic [63:0]  m_iv, m_s1, m_s2;
    bit           m_act;

    function automatic logic [7:0] m_read();
        case (m_sel)
            8'h03: return {5'b0, m_out.size() == 0, m_in.size() == 8, m_act};
            8'h04: case (m_idx)
                8'h00: return m_cfg;
                8'h02: return m_dma;
                8'h0B: return m_dbc;
                8'h10: return {4'b0, m_kp[0]};
                8'h11: return {4'b0, m_kp[1]};
                8'h12: return {4'b0, m_kp[2]};
                8'h13: return m_mode;
                default: return 8'h00;
            endcase
            8'h08: return (m_out.size() > 0) ? m_out[0] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_idx = 0; m_cfg = 0; m_dma = 0; m_mode = 0; m_dbc = 0;
            m_kp[0] = 0; m_kp[1] = 0; m_kp[2] = 0;
            m_iv = 0; m_s1 = 0; m_s2 = 0; m_act = 0;
            m_in.delete(); m_out.delete();
        end else begin
            bit          iw, go;
            logic [63:0] blk;
            iw = dat_we && m_sel == 8'h04;
            go = m_act && m_in.size() == 8 && m_out.size() == 0 && !iw;
            if (go) begin
                blk = 0;
                foreach (m_in[i]) blk = {blk[55:0], m_in[i]};
                blk = blk ^ m_iv;
                m_in.delete();
                m_out.delete();
                for (int i = 7; i >= 0; i--) m_out.push_back(blk[i*8 +: 8]);
                m_iv = m_iv + 1;
                m_dbc = m_dbc + 1;
            end else if (iw) begin
                case (m_idx)
                    8'h00: m_cfg = dat_wdata;
                    8'h02: m_dma = dat_wdata;
                    8'h03: m_iv = {m_iv[55:0], dat_wdata};
                    8'h0B: m_dbc = dat_wdata;
                    8'h10: m_kp[0] = dat_wdata[3:0];
                    8'h11: if (m_mode[1]) m_kp[1] = dat_wdata[3:0];
                    8'h12: if (m_mode[1]) m_kp[2] = dat_wdata[3:0];
                    8'h13: m_mode = dat_wdata;
                    8'h14: case (dat_wdata)
                        8'h00: begin m_act = 0; m_in.delete(); m_out.delete(); end
                        8'h01: m_act = 1;
                        8'h04: begin m_act = 0; m_s1 = m_iv; end
                        8'h06: begin m_act = 0; m_s2 = m_iv; end
                        8'h05: if (!m_act) begin m_iv = m_s1; m_act = 1; end
                        8'h07: if (!m_act) begin m_iv = m_s2; m_act = 1; end
                        8'h08: begin
                            m_act = 0; m_in.delete(); m_out.delete();
                            m_cfg = 0; m_dma = 0; m_mode = 0; m_dbc = 0;
                            m_kp[0] = 0; m_kp[1] = 0; m_kp[2] = 0;
                        end
                        default: ;
                    endcase
                    default: ;
                endcase
            end
            if (dat_we && m_sel == 8'h08 && m_in.size() < 8) m_in.push_back(dat_wdata);
            if (dat_re && !dat_we && m_sel == 8'h08 && m_out.size() > 0) void'(m_out.pop_front());
            if (dat_we && m_sel == 8'h03) m_idx = dat_wdata;
            if (sel_we) m_sel = sel_val;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #2;
        if (mon_on) begin
            n_chk++;
            if (dat_rdata !== m_read() || cipher_active !== m_act) begin
                n_bad++;
                $display("FAIL %s model compare: rdata=%02h act=%0b expected rdata=%02h act=%0b",
                         cur_req, dat_rdata, cipher_active, m_read(), m_act);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(bit sw, logic [7:0] sv, bit w, bit r, logic [7:0] d);
        @(negedge clk);
        sel_we = sw; sel_val = sv; dat_we = w; dat_re = r; dat_wdata = d;
        #1;
    endtask

    task automatic setsel(logic [7:0] v); cyc(1, v, 0, 0, 0); endtask
    task automatic wr(logic [7:0] d); cyc(0, 0, 1, 0, d); endtask
    task automatic idle(int n); repeat (n) cyc(0, 0, 0, 0, 0); endtask

    task automatic rdc(string req, logic [7:0] exp);
        cyc(0, 0, 0, 1, 0);
        check(req, dat_rdata, exp);
    endtask

    task automatic iwrite(logic [7:0] idx, logic [7:0] d);
        setsel(8'h03); wr(idx); setsel(8'h04); wr(d);
    endtask

    task automatic iread(string req, logic [7:0] idx, logic [7:0] exp);
        setsel(8'h03); wr(idx); setsel(8'h04); rdc(req, exp);
    endtask

    task automatic status(string req, logic [7:0] exp);
        setsel(8'h03); rdc(req, exp);
    endtask

    task automatic blk_zero(string req, logic [63:0] exp);
        setsel(8'h08);
        repeat (8) wr(8'h00);
        idle(2);
        for (int i = 7; i >= 0; i--) rdc(req, exp[i*8 +: 8]);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;

        cur_req = "R1";
        status("R1", 8'h04);
        iread("R1", 8'h13, 8'h00);
        iread("R1", 8'h0B, 8'h00);

        cur_req = "R5";
        iwrite(8'h13, 8'h12);
        iread("R5", 8'h13, 8'h12);
        iwrite(8'h00, 8'h03);
        iwrite(8'h02, 8'h1F);
        iread("R5", 8'h00, 8'h03);
        iread("R5", 8'h02, 8'h1F);
        iread("R5", 8'h07, 8'h00);

        cur_req = "R4";
        iwrite(8'h10, 8'h01);
        iwrite(8'h11, 8'h02);
        iwrite(8'h12, 8'h33);
        iread("R4", 8'h12, 8'h03);
        iwrite(8'h13, 8'h10);
        iwrite(8'h11, 8'h09);
        iwrite(8'h12, 8'h0A);
        iread("R4", 8'h11, 8'h02);
        iread("R4", 8'h12, 8'h03);
        iwrite(8'h10, 8'h07);
        iread("R4", 8'h10, 8'h07);

        cur_req = "R2";
        setsel(8'h03); wr(8'h13); setsel(8'h04);
        rdc("R2", 8'h10);
        setsel(8'h03);
        rdc("R2", 8'h04);
        rdc("R2", 8'h04);
        setsel(8'h04);
        rdc("R2", 8'h10);

        cur_req = "R3";
        setsel(8'h03); wr(8'h03); setsel(8'h04);
        for (int i = 1; i <= 8; i++) wr(8'(i));

        cur_req = "R11";
        iwrite(8'h14, 8'h01);
        status("R6", 8'h05);
        blk_zero("R3", 64'h0102030405060708);
        iread("R11", 8'h0B, 8'h01);

        cur_req = "R6";
        iwrite(8'h14, 8'h05);
        status("R6", 8'h05);
        blk_zero("R6", 64'h0102030405060709);

        cur_req = "R7";
        iwrite(8'h14, 8'h04);
        status("R7", 8'h04);
        iwrite(8'h14, 8'h06);
        status("R7", 8'h04);
        setsel(8'h03); wr(8'h03); setsel(8'h04);
        repeat (8) wr(8'hFF);
        cur_req = "R8";
        iwrite(8'h14, 8'h07);
        status("R8", 8'h05);
        blk_zero("R8", 64'h010203040506070A);
        iread("R8", 8'h0B, 8'h03);

        cur_req = "R9";
        setsel(8'h08);
        repeat (3) wr(8'h55);
        status("R9", 8'h05);
        iwrite(8'h14, 8'h00);
        status("R9", 8'h04);
        setsel(8'h08);
        repeat (10) wr(8'hAA);
        status("R11", 8'h06);

        cur_req = "R12";
        iwrite(8'h0B, 8'hFF);
        iwrite(8'h14, 8'h01);
        idle(2);
        iread("R12", 8'h0B, 8'h00);
        setsel(8'h08);
        rdc("R11", 8'hAB); rdc("R11", 8'hA8); rdc("R11", 8'hA9); rdc("R11", 8'hAE);
        rdc("R11", 8'hAF); rdc("R11", 8'hAC); rdc("R11", 8'hAD); rdc("R11", 8'hA1);
        rdc("R11", 8'h00);

        cur_req = "R10";
        iwrite(8'h14, 8'h08);
        iread("R10", 8'h00, 8'h00);
        iread("R10", 8'h02, 8'h00);
        iread("R10", 8'h13, 8'h00);
        iread("R10", 8'h10, 8'h00);
        iread("R10", 8'h0B, 8'h00);
        status("R10", 8'h04);
        iwrite(8'h14, 8'h01);
        blk_zero("R10", 64'h010203040506070C);
        iwrite(8'h14, 8'h00);
        iwrite(8'h14, 8'h05);
        blk_zero("R10", 64'h010203040506070A);

        idle(3);
        mon_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule